// File: doc/BRIEF.md
# Frequency-Compensated System Time Clock

This block keeps a 64-bit time-of-day counter that advances at a programmable average rate below the core clock. A 32-bit rate word, the addend, is summed into a 32-bit phase accumulator on every core clock cycle. Each cycle in which that sum overflows advances the time counter by one. Firmware picks the tick frequency by writing addend = 2^32 / (f_core / f_tick), and the ratio must be greater than 1. With a 100 MHz core clock, 0xCCCCCCCD gives 80 MHz. 0xAAAAAAAB gives about 66.66 MHz, and 0xD5555555 gives about 83.33 MHz. One addend LSB moves the rate by 2^-32 of the core clock, which is finer than one part per billion.

Firmware can retune the rate at any moment without a phase jump. It can set the counter to an absolute 64-bit value. It reads the time through a snapshot register: a single strobe freezes all 64 bits, which are then read as two 32-bit words.

Top module: `stc_sys_time`

## Requirements
- R1: After reset, `time_now` is zero, `tick` is low, and `rd_data` returns zero for both halves. The addend and the accumulator are also zero.
- R2: While the addend is zero and no load is applied, `time_now` does not change.
- R3: On every clock edge without a load, the accumulator becomes (accumulator + addend) mod 2^32. `time_now` increases by exactly one on the edges where that 33-bit sum has bit 32 set, and holds otherwise. `tick` shows that carry ahead of the edge.
- R4: Starting from a cleared accumulator, the count of increments after N edges is floor(N × addend / 2^32). Over 1000 edges this gives 800 increments for 0xCCCCCCCD, 666 for 0xAAAAAAAB and 833 for 0xD5555555.
- R5: A value written with `addend_we` is used from the following edge onwards. The write does not alter the accumulator contents.
- R6: `load_stb` sets `time_now` to `load_value` and clears the accumulator on the same edge. If a carry occurs on that edge, it is discarded: the load wins.
- R7: `capture_stb` copies all 64 bits of `time_now`, as seen before that edge, into a snapshot. The snapshot holds until the next capture. `rd_sel` = 0 returns bits 31:0 and `rd_sel` = 1 returns bits 63:32 on `rd_data`, combinationally.
- R8: An increment from all ones wraps `time_now` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| addend_we | input | 1 | Write strobe for the rate word |
| addend_wdata | input | 32 | New rate word |
| load_stb | input | 1 | Absolute time load strobe |
| load_value | input | 64 | Time value to load |
| capture_stb | input | 1 | Snapshot strobe |
| rd_sel | input | 1 | Snapshot half select (0 low, 1 high) |
| rd_data | output | 32 | Selected snapshot half |
| time_now | output | 64 | Live time counter |
| tick | output | 1 | Accumulator carry for the current cycle |

## Verification
The assertions assume that every input carries a known value when the rising edge samples it. They also assume that `addend_wdata` and `load_value` matter only in cycles where their strobe is high, so a property may relate the state after an edge to the strobe and data sampled at that edge. The bench drives every input on the falling edge, so the values are settled long before the rising edge. Its random stimulus keeps the strobes sparse and independent of one another. This lets loads, captures and addend writes collide with carries and with each other in any combination, without breaking those assumptions.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;
  // Update chosen for the time counter on a given edge
  typedef enum logic [1:0] {
    STC_HOLD = 2'd0,
    STC_STEP = 2'd1,
    STC_LOAD = 2'd2
  } stc_op_e;

  function automatic stc_op_e stc_pick_op(input logic load, input logic carry);
    if (load)       return STC_LOAD;
    else if (carry) return STC_STEP;
    else            return STC_HOLD;
  endfunction
endpackage

// File: rtl/stc_phase_accum.sv
`timescale 1ns/1ps
module stc_phase_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  input  logic             clear,
  output logic             carry_o
);
  logic [ACC_W-1:0] addend_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_w;

  // Full-width add; the top bit is the overflow that paces the time counter
  function automatic logic [ACC_W:0] phase_sum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum_w   = phase_sum(acc_q, addend_q);
  assign carry_o = sum_w[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addend_q <= '0;
    end else if (addend_we) begin
      addend_q <= addend_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else begin
      acc_q <= sum_w[ACC_W-1:0];
    end
  end

  AST_ADDEND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    addend_we |=> addend_q == $past(addend_wdata)); // R5
  AST_ADDEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addend_we |=> $stable(addend_q)); // R5
  AST_ACC_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc_q == '0); // R6
  AST_ACC_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> acc_q == ACC_W'($past(acc_q) + $past(addend_q))); // R3
endmodule

// File: rtl/stc_time_counter.sv
`timescale 1ns/1ps
module stc_time_counter
  import stc_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] load_value,
  input  logic              carry,
  output logic [TIME_W-1:0] time_q
);
  stc_op_e op_w;

  function automatic logic [TIME_W-1:0] next_time(input stc_op_e op,
                                                  input logic [TIME_W-1:0] cur,
                                                  input logic [TIME_W-1:0] ld);
    case (op)
      STC_LOAD: return ld;
      STC_STEP: return cur + TIME_W'(1);
      default:  return cur;
    endcase
  endfunction

  assign op_w = stc_pick_op(load, carry);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
    end else begin
      time_q <= next_time(op_w, time_q, load_value);
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> time_q == $past(load_value)); // R6
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && carry) |=> time_q == $past(time_q) + TIME_W'(1)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !carry) |=> $stable(time_q)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && carry && (&time_q)) |=> time_q == '0); // R8
endmodule

// File: rtl/stc_read_shadow.sv
`timescale 1ns/1ps
module stc_read_shadow #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned RD_W   = 32,
  localparam int unsigned SLOTS = TIME_W / RD_W,
  localparam int unsigned SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [TIME_W-1:0] time_in,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [RD_W-1:0]   rd_data
);
  logic [TIME_W-1:0] shadow_q;
  logic [RD_W-1:0]   slice_w [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (capture) begin
      shadow_q <= time_in;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slice
    assign slice_w[s] = shadow_q[s*RD_W +: RD_W];
  end

  always_comb begin
    rd_data = slice_w[0];
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_sel == SEL_W'(s)) rd_data = slice_w[s];
    end
  end

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> shadow_q == $past(time_in)); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(shadow_q)); // R7
endmodule

// File: rtl/stc_sys_time.sv
`timescale 1ns/1ps
module stc_sys_time #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned TIME_W = 64,
  parameter int unsigned RD_W   = 32,
  localparam int unsigned SLOTS = TIME_W / RD_W,
  localparam int unsigned SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addend_we,
  input  logic [ACC_W-1:0]  addend_wdata,
  input  logic              load_stb,
  input  logic [TIME_W-1:0] load_value,
  input  logic              capture_stb,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [RD_W-1:0]   rd_data,
  output logic [TIME_W-1:0] time_now,
  output logic              tick
);
  logic carry_w;

  stc_phase_accum #(.ACC_W(ACC_W)) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .addend_we    (addend_we),
    .addend_wdata (addend_wdata),
    .clear        (load_stb),
    .carry_o      (carry_w)
  );

  stc_time_counter #(.TIME_W(TIME_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_stb),
    .load_value (load_value),
    .carry      (carry_w),
    .time_q     (time_now)
  );

  stc_read_shadow #(.TIME_W(TIME_W), .RD_W(RD_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture_stb),
    .time_in (time_now),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  assign tick = carry_w;

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (time_now == '0 && !tick)); // R1
endmodule

// File: tb/stc_sys_time_test.sv
`timescale 1ns/1ps
module stc_sys_time_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addend_we;
  logic [31:0] addend_wdata;
  logic        load_stb;
  logic [63:0] load_value;
  logic        capture_stb;
  logic        rd_sel;
  logic [31:0] rd_data;
  logic [63:0] time_now;
  logic        tick;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench's own model of the block
  logic [31:0] m_add, m_acc;
  logic [63:0] m_time, m_shadow;

  always #10 clk = ~clk;

  stc_sys_time uut (
    .clk(clk), .rst_n(rst_n), .addend_we(addend_we), .addend_wdata(addend_wdata),
    .load_stb(load_stb), .load_value(load_value), .capture_stb(capture_stb),
    .rd_sel(rd_sel), .rd_data(rd_data), .time_now(time_now), .tick(tick)
  );

  function automatic logic model_carry(input logic [31:0] acc, input logic [31:0] add);
    logic [32:0] s;
    s = {1'b0, acc} + {1'b0, add};
    return s[32];
  endfunction

  function automatic logic [31:0] model_half(input logic [63:0] v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at falling edge, advance model at rising edge, compare at next falling edge
  task automatic step(input logic we, input logic [31:0] wd, input logic ld,
                      input logic [63:0] lv, input logic cap, input logic sel,
                      input string tag);
    logic c;
    addend_we = we; addend_wdata = wd; load_stb = ld; load_value = lv;
    capture_stb = cap; rd_sel = sel;
    #1;
    check({tag, " tick"}, {63'd0, tick}, {63'd0, model_carry(m_acc, m_add)});
    @(posedge clk);
    c = model_carry(m_acc, m_add);
    if (cap) m_shadow = m_time;
    if (ld) begin
      m_time = lv;
      m_acc  = '0;
    end else begin
      m_acc = m_acc + m_add;
      if (c) m_time = m_time + 64'd1;
    end
    if (we) m_add = wd;
    @(negedge clk);
    check({tag, " time"}, time_now, m_time);
    check({tag, " rd_data"}, {32'd0, rd_data}, {32'd0, model_half(m_shadow, sel)});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic rate_window(input logic [31:0] a, input logic [63:0] exp_cnt);
    step(1'b1, a, 1'b1, 64'd0, 1'b0, 1'b0, "R4 setup");
    idle(1000, "R4 run");
    check("R4 count over 1000 edges", time_now, exp_cnt);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; addend_we = 0; addend_wdata = '0; load_stb = 0; load_value = '0;
    capture_stb = 0; rd_sel = 0;
    m_add = '0; m_acc = '0; m_time = '0; m_shadow = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 time", time_now, 64'd0);
    check("R1 tick", {63'd0, tick}, 64'd0);
    check("R1 rd lo", {32'd0, rd_data}, 64'd0);
    rd_sel = 1'b1; #1;
    check("R1 rd hi", {32'd0, rd_data}, 64'd0);

    // R2: zero addend leaves time still
    idle(40, "R2");
    check("R2 time frozen", time_now, 64'd0);

    // R4: exact counts for the three example rates
    rate_window(32'hCCCCCCCD, 64'd800);
    rate_window(32'hAAAAAAAB, 64'd666);
    rate_window(32'hD5555555, 64'd833);

    // R5: retune mid-run, phase kept
    step(1'b1, 32'h4000_0000, 1'b0, '0, 1'b0, 1'b0, "R5 write");
    idle(20, "R5 after");
    step(1'b1, 32'h0000_0000, 1'b0, '0, 1'b0, 1'b0, "R5 stop");
    idle(10, "R5 frozen");

    // R6: load collides with a carry
    step(1'b1, 32'hFFFF_FFFF, 1'b0, '0, 1'b0, 1'b0, "R6 prep");
    idle(3, "R6 prep run");
    check("R6 carry pending", {63'd0, tick}, 64'd1);
    step(1'b0, '0, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, "R6 load");
    check("R6 loaded value", time_now, 64'h0123_4567_89AB_CDEF);
    check("R6 acc cleared, no carry", {63'd0, tick}, 64'd0);
    idle(5, "R6 after");

    // R8: wrap from all ones
    step(1'b1, 32'h8000_0000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0, "R8 load");
    idle(4, "R8 run");
    check("R8 wrapped", time_now, 64'd0);

    // R7: snapshot held while time runs on
    step(1'b1, 32'h9000_0000, 1'b1, 64'hAAAA_5555_FFFF_FFF0, 1'b0, 1'b0, "R7 load");
    idle(30, "R7 run");
    step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R7 capture");
    idle(40, "R7 hold");
    rd_sel = 1'b1; #1;
    check("R7 hi half", {32'd0, rd_data}, {32'd0, m_shadow[63:32]});
    rd_sel = 1'b0; #1;
    check("R7 lo half", {32'd0, rd_data}, {32'd0, m_shadow[31:0]});

    // R3: random mix against the model
    for (int i = 0; i < 5000; i++) begin
      logic        we, ld, cap;
      logic [63:0] lv;
      we  = ($urandom % 64) == 0;
      ld  = ($urandom % 200) == 0;
      cap = ($urandom % 16) == 0;
      lv  = {$urandom, $urandom};
      if (($urandom % 8) == 0) lv[63:8] = '1;
      step(we, $urandom, ld, lv, cap, 1'($urandom), "R3 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule